// File: doc/BRIEF.md
# Horizontal Pixel Panning Unit

This block turns a stored 4-bit horizontal panning value into the pixel shift count used by a display pipeline. The meaning of the stored value depends on the current display mode: in character mode the result depends on whether cells are 8 or 9 dots wide, in 256-colour packed mode the shift is halved, and in the other graphics modes the low three bits are used directly. The pixel shifter itself sits downstream and is not part of this block.

A split-screen option is also provided. When it is enabled, a line compare match forces the shift to zero. The shift stays at zero until the next vertical retrace, and then the programmed value applies again. The result is registered once per scanline on a line-start pulse, so a register write in the middle of a line cannot tear that line. Any change to the panning value, the cell width or the mode takes effect on the next line.

Top module: `pel_pan_unit`

## Requirements
- R1: With mode code 2'b00 (character mode) and `cell9` high, panning value n in 0..7 gives a shift of n+1.
- R2: With mode code 2'b00 and `cell9` low, panning value n in 0..7 gives a shift of n.
- R3: With mode code 2'b00, panning values 8..15 give a shift of 0 whether `cell9` is high or low.
- R4: With mode code 2'b01 (256-colour packed), the shift is (value AND 7) shifted right by one, so it never exceeds 3.
- R5: With mode code 2'b10 or 2'b11 (other graphics), the shift is the value AND 7, and `cell9` has no effect.
- R6: While `split_en` is high, a `line_match` pulse arms an override. Every line latched while the override is armed gives a shift of 0.
- R7: A `vretrace` pulse clears the override. The next line latched after that gives the mapped value again.
- R8: `shift_out` changes only in the cycle after a `line_start` pulse. Input changes made between line starts leave it unchanged until the next line start, which then uses the new inputs.
- R9: While `split_en` is low, a `line_match` pulse has no effect on the latched shift.
- R10: After reset, `shift_out` is 0 and the override is clear.
- R11: When `line_match` and `vretrace` arrive in the same cycle, the retrace takes priority and the override stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pan_val | input | 4 | Stored horizontal panning value |
| cell9 | input | 1 | Character cells are 9 dots wide |
| split_en | input | 1 | Enables the zero-shift override after a line compare match |
| disp_mode | input | 2 | 00 character, 01 256-colour packed, 10/11 other graphics |
| line_match | input | 1 | One-cycle line compare match pulse |
| vretrace | input | 1 | One-cycle vertical retrace pulse |
| line_start | input | 1 | One-cycle start-of-scanline pulse |
| shift_out | output | 4 | Latched pixel shift count for the current line |

## Verification
The mapped shift appears on `shift_out` one cycle after the `line_start` pulse, through a single register. The bench therefore pulses `line_start` for one cycle at a falling edge and samples `shift_out` on the following falling edge. The override flag needs one clock edge to arm or clear. For that reason, each `line_match` or `vretrace` pulse is given its own cycle before the next line start, except in the same-cycle priority test. Checks that a mid-line change has no effect sample `shift_out` several cycles after the change with no line start in between, and only then start a line and look for the new value.

// File: rtl/pel_pan_pkg.sv
package pel_pan_pkg;
  typedef enum logic [1:0] {
    MD_CHAR    = 2'b00,
    MD_PACKED8 = 2'b01,
    MD_GFX     = 2'b10,
    MD_GFX_ALT = 2'b11
  } disp_mode_e;
endpackage

// File: rtl/pel_pan_map.sv
module pel_pan_map
  import pel_pan_pkg::*;
#(
  parameter int PAN_W   = 4,
  parameter int SHIFT_W = 4
) (
  input  logic [PAN_W-1:0]   pan_val,
  input  logic               cell9,
  input  disp_mode_e         mode,
  output logic [SHIFT_W-1:0] shift
);
  // Largest value that is still a legal character-mode pan step.
  localparam int TEXT_LIMIT = (1 << (PAN_W - 1)) - 1;
  localparam logic [PAN_W-1:0] LOW_MASK = PAN_W'(TEXT_LIMIT);

  logic [PAN_W-1:0] low;
  assign low = pan_val & LOW_MASK;

  always_comb begin
    unique case (mode)
      MD_CHAR: begin
        if (pan_val > LOW_MASK)
          shift = '0;
        else if (cell9)
          shift = SHIFT_W'(low) + SHIFT_W'(1);
        else
          shift = SHIFT_W'(low);
      end
      MD_PACKED8: shift = SHIFT_W'(low >> 1);
      default:    shift = SHIFT_W'(low);
    endcase
  end
endmodule

// File: rtl/pel_split_hold.sv
module pel_split_hold (
  input  logic clk,
  input  logic rst,
  input  logic split_en,
  input  logic line_match,
  input  logic vretrace,
  output logic armed
);
  always_ff @(posedge clk) begin
    if (rst)
      armed <= 1'b0;
    else if (vretrace)
      armed <= 1'b0;
    else if (line_match && split_en)
      armed <= 1'b1;
  end

  p_arm_r6: assert property (@(posedge clk) disable iff (rst)
    (line_match && split_en && !vretrace) |=> armed);

  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    vretrace |=> !armed);

  p_no_arm_r9: assert property (@(posedge clk) disable iff (rst)
    (!armed && !split_en) |=> !armed);

  p_retrace_wins_r11: assert property (@(posedge clk) disable iff (rst)
    (line_match && vretrace) |=> !armed);
endmodule

// File: rtl/pel_shift_latch.sv
module pel_shift_latch #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         force_zero,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)
      q <= '0;
    else if (load)
      q <= force_zero ? '0 : d;
  end

  p_midline_stable_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load)) |-> $stable(q));

  p_reset_zero_r10: assert property (@(posedge clk)
    $past(rst) |-> (q == '0));
endmodule

// File: rtl/pel_pan_unit.sv
module pel_pan_unit
  import pel_pan_pkg::*;
#(
  parameter int PAN_W   = 4,
  parameter int SHIFT_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PAN_W-1:0]   pan_val,
  input  logic               cell9,
  input  logic               split_en,
  input  logic [1:0]         disp_mode,
  input  logic               line_match,
  input  logic               vretrace,
  input  logic               line_start,
  output logic [SHIFT_W-1:0] shift_out
);
  disp_mode_e         mode;
  logic [SHIFT_W-1:0] mapped;
  logic               armed;
  logic               force_zero;

  assign mode       = disp_mode_e'(disp_mode);
  assign force_zero = armed && split_en;

  pel_pan_map #(.PAN_W(PAN_W), .SHIFT_W(SHIFT_W)) u_map (
    .pan_val (pan_val),
    .cell9   (cell9),
    .mode    (mode),
    .shift   (mapped)
  );

  pel_split_hold u_hold (
    .clk        (clk),
    .rst        (rst),
    .split_en   (split_en),
    .line_match (line_match),
    .vretrace   (vretrace),
    .armed      (armed)
  );

  pel_shift_latch #(.W(SHIFT_W)) u_latch (
    .clk        (clk),
    .rst        (rst),
    .load       (line_start),
    .force_zero (force_zero),
    .d          (mapped),
    .q          (shift_out)
  );

  p_char_bound_r1: assert property (@(posedge clk) disable iff (rst)
    (line_start && disp_mode == 2'b00) |=> (shift_out <= SHIFT_W'(8)));

  p_packed_bound_r4: assert property (@(posedge clk) disable iff (rst)
    (line_start && disp_mode == 2'b01) |=> (shift_out <= SHIFT_W'(3)));

  p_split_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (line_start && armed && split_en) |=> (shift_out == '0));
endmodule

// File: tb/tb_pel_pan_unit.sv
module tb_pel_pan_unit;
  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] pan_val;
  logic       cell9;
  logic       split_en;
  logic [1:0] disp_mode;
  logic       line_match;
  logic       vretrace;
  logic       line_start;
  logic [3:0] shift_out;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  pel_pan_unit dut (
    .clk(clk), .rst(rst), .pan_val(pan_val), .cell9(cell9),
    .split_en(split_en), .disp_mode(disp_mode), .line_match(line_match),
    .vretrace(vretrace), .line_start(line_start), .shift_out(shift_out)
  );

  // {mode[1:0], cell9, pan[3:0], expected[3:0]}
  localparam logic [10:0] VEC [16] = '{
    {2'd0, 1'b1, 4'd3,  4'd4},
    {2'd0, 1'b1, 4'd7,  4'd8},
    {2'd0, 1'b1, 4'd0,  4'd1},
    {2'd0, 1'b1, 4'd8,  4'd0},
    {2'd0, 1'b1, 4'd15, 4'd0},
    {2'd0, 1'b0, 4'd0,  4'd0},
    {2'd0, 1'b0, 4'd7,  4'd7},
    {2'd0, 1'b0, 4'd9,  4'd0},
    {2'd1, 1'b0, 4'd7,  4'd3},
    {2'd1, 1'b1, 4'd6,  4'd3},
    {2'd1, 1'b0, 4'd5,  4'd2},
    {2'd1, 1'b0, 4'd1,  4'd0},
    {2'd1, 1'b0, 4'd14, 4'd3},
    {2'd2, 1'b0, 4'd13, 4'd5},
    {2'd2, 1'b1, 4'd7,  4'd7},
    {2'd3, 1'b1, 4'd10, 4'd2}
  };

  function automatic string req_of(logic [1:0] m, logic c, logic [3:0] p);
    if (m == 2'd0 && p > 4'd7) return "R3";
    if (m == 2'd0 && c)        return "R1";
    if (m == 2'd0)             return "R2";
    if (m == 2'd1)             return "R4";
    return "R5";
  endfunction

  function automatic logic [3:0] model(logic [1:0] m, logic c, logic [3:0] p);
    if (m == 2'd0) return (p > 4'd7) ? 4'd0 : (c ? p + 4'd1 : p);
    if (m == 2'd1) return {1'b0, p[2:0]} >> 1;
    return {1'b0, p[2:0]};
  endfunction

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: shift_out=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_line();
    @(negedge clk) line_start = 1'b1;
    @(negedge clk) line_start = 1'b0;
  endtask

  task automatic pulse_match();
    @(negedge clk) line_match = 1'b1;
    @(negedge clk) line_match = 1'b0;
  endtask

  task automatic pulse_retrace();
    @(negedge clk) vretrace = 1'b1;
    @(negedge clk) vretrace = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; pan_val = 4'd5; cell9 = 1'b0; split_en = 1'b0;
    disp_mode = 2'd2; line_match = 1'b0; vretrace = 1'b0; line_start = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10", shift_out, 4'd0);

    // Table-driven mapping
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      disp_mode = VEC[i][10:9];
      cell9     = VEC[i][8];
      pan_val   = VEC[i][7:4];
      do_line();
      check(req_of(VEC[i][10:9], VEC[i][8], VEC[i][7:4]), shift_out, VEC[i][3:0]);
    end

    // Full sweep against the bench model
    for (int m = 0; m < 4; m++)
      for (int c = 0; c < 2; c++)
        for (int p = 0; p < 16; p++) begin
          @(negedge clk);
          disp_mode = 2'(m); cell9 = 1'(c); pan_val = 4'(p);
          do_line();
          check(req_of(2'(m), 1'(c), 4'(p)), shift_out, model(2'(m), 1'(c), 4'(p)));
        end

    // R8: a mid-line change is not seen until the next line start
    @(negedge clk); disp_mode = 2'd2; cell9 = 1'b0; pan_val = 4'd6;
    do_line();
    check("R8", shift_out, 4'd6);
    @(negedge clk); pan_val = 4'd3;
    repeat (3) @(negedge clk);
    check("R8", shift_out, 4'd6);
    do_line();
    check("R8", shift_out, 4'd3);
    // R8: changing the cell width is picked up on the next line
    @(negedge clk); disp_mode = 2'd0; cell9 = 1'b0; pan_val = 4'd4;
    do_line();
    check("R8", shift_out, 4'd4);
    @(negedge clk); cell9 = 1'b1;
    repeat (2) @(negedge clk);
    check("R8", shift_out, 4'd4);
    do_line();
    check("R8", shift_out, 4'd5);

    // R6 / R7: split override
    @(negedge clk); split_en = 1'b1;
    pulse_match();
    do_line();
    check("R6", shift_out, 4'd0);
    do_line();
    check("R6", shift_out, 4'd0);
    pulse_retrace();
    do_line();
    check("R7", shift_out, 4'd5);

    // R9: match with the option disabled
    @(negedge clk); split_en = 1'b0;
    pulse_match();
    do_line();
    check("R9", shift_out, 4'd5);
    @(negedge clk); split_en = 1'b1;
    do_line();
    check("R9", shift_out, 4'd5);

    // R11: simultaneous match and retrace
    @(negedge clk); line_match = 1'b1; vretrace = 1'b1;
    @(negedge clk); line_match = 1'b0; vretrace = 1'b0;
    do_line();
    check("R11", shift_out, 4'd5);

    // R10: reset mid-run clears output and override
    pulse_match();
    do_line();
    check("R6", shift_out, 4'd0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R10", shift_out, 4'd0);
    do_line();
    check("R10", shift_out, 4'd5);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule